// File: doc/BRIEF.md
# Channel Command Word Load/Store Unit

This block keeps the control registers of one data channel: a 15-bit location counter, a 15-bit address counter, a 15-bit word counter, four indicator bits and a small set of pending status flags. It does two jobs. It fetches a 36-bit command word from memory and spreads its fields over the registers. It also writes the counters and indicators back to memory as one 36-bit word.

A request is a one-cycle `start` pulse with an operation code and a 15-bit operand address. Every request runs a short fixed sequence. First there is a setup cycle (the L phase). In that cycle a fetch records the command-word address in the location counter, and the reset variant also clears the pending status flags. Next comes one memory request cycle (the E phase). A fetch then waits for read data, and a store finishes as soon as its write is issued. A one-cycle `done` pulse closes every operation.

Word bits are numbered S, 1, 2, …, 35, with S as the most significant bit. Bit n of that numbering sits at vector index 35−n.

Top module: `ccw_unit`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, and all counters, indicators and status flags read 0.
- R2: On a fetch (op 2'b00 or 2'b01), `loc_q` takes the value of `cmd_addr` at the end of the L phase, which is the cycle after `start` is sampled. This happens before the memory request is issued.
- R3: The cycle after the L phase, `mem_req` is high for exactly one cycle with `mem_addr` equal to the operand address. `mem_we` is 0 for a fetch and 1 for a store (op 2'b10).
- R4: When `mem_rvalid` arrives during a fetch, the following fields of `mem_rdata` are loaded:
  - word bits S, 1, 2 and 19 go to `ind_q[3]`, `ind_q[2]`, `ind_q[1]` and `ind_q[0]`;
  - bits 3–17 go to `wc_q`;
  - bits 21–35 go to `addr_q`;
  - bits 18 and 20 have no effect.
- R5: The reset-and-load fetch (op 2'b01) clears `status_q` at the end of its L phase. A plain fetch (op 2'b00) leaves `status_q` unchanged.
- R6: During a store's write cycle, `mem_wdata` carries:
  - `ind_q[3:0]` in bits S, 1, 2 and 19;
  - `loc_q` in bits 3–17;
  - `addr_q` in bits 21–35;
  - zeros in every other bit.
- R7: A store changes none of `loc_q`, `addr_q`, `wc_q` or `ind_q`.
- R8: `done` is high for exactly one cycle. For a fetch it comes in the cycle after the registers load. For a store it comes in the cycle after the write request.
- R9: A `start` while `busy` is high is ignored, and so is a `start` with op 2'b11.
- R10: `mem_rvalid` outside a pending fetch changes no register.
- R11: Each bit set in `status_set` sets the matching `status_q` bit, which then holds until a reset-and-load clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse |
| op | input | 2 | 00 fetch, 01 reset-and-fetch, 10 store, 11 none |
| cmd_addr | input | 15 | Command-word address or store address |
| status_set | input | STATUS_W | Sets pending status flags |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| loc_q | output | 15 | Location counter |
| addr_q | output | 15 | Address counter |
| wc_q | output | 15 | Word counter |
| ind_q | output | 4 | Indicators |
| status_q | output | STATUS_W | Pending status flags |

## Verification
The bench builds the block with its default packing and `STATUS_W` = 2, which is small enough to set and clear every flag combination. It sweeps all 16 indicator patterns against a walking one in the counter fields. Each pattern is fetched with junk in the unused bits 18 and 20 and then stored back, so every field boundary of both the unpacking and the packing is exercised. Separate runs cover the status clear, a `start` during a busy phase, op 11, and a stray `mem_rvalid`.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
  localparam int WORD_W = 36;
  localparam int CNT_W  = 15;
  localparam int IND_W  = 4;
  // vector index of numbered word bit n (S = bit 0 = MSB)
  localparam int CNT_HI = WORD_W - 1 - 3;
  localparam int ADR_HI = WORD_W - 1 - 21;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_RLOAD = 2'b01,
    OP_STORE = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LPH, ST_REQ, ST_WAIT, ST_DONE
  } state_e;

  // indicator i (0 = least significant) -> vector index
  function automatic int ind_pos(input int i);
    case (i)
      3:       ind_pos = WORD_W - 1 - 0;
      2:       ind_pos = WORD_W - 1 - 1;
      1:       ind_pos = WORD_W - 1 - 2;
      default: ind_pos = WORD_W - 1 - 19;
    endcase
  endfunction
endpackage

// File: rtl/ccw_seq.sv
module ccw_seq
  import ccw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic [1:0] op,
  input  logic rvalid,
  output logic accept,
  output logic lph,
  output logic req,
  output logic fill,
  output logic done,
  output logic busy,
  output logic is_store,
  output logic is_rload
);
  state_e state_q, state_d;
  op_e    op_q, op_d;

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    accept  = 1'b0;
    fill    = 1'b0;
    case (state_q)
      ST_IDLE: if (start && op_e'(op) != OP_NONE) begin
        accept  = 1'b1;
        op_d    = op_e'(op);
        state_d = ST_LPH;
      end
      ST_LPH:  state_d = ST_REQ;
      ST_REQ:  state_d = (op_q == OP_STORE) ? ST_DONE : ST_WAIT;
      ST_WAIT: if (rvalid) begin
        fill    = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
    end
  end

  assign lph      = (state_q == ST_LPH);
  assign req      = (state_q == ST_REQ);
  assign done     = (state_q == ST_DONE);
  assign busy     = (state_q != ST_IDLE);
  assign is_store = (op_q == OP_STORE);
  assign is_rload = (op_q == OP_RLOAD);
endmodule

// File: rtl/ccw_pack.sv
module ccw_pack
  import ccw_pkg::*;
(
  input  logic [IND_W-1:0]  ind,
  input  logic [CNT_W-1:0]  loc,
  input  logic [CNT_W-1:0]  adr,
  output logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rdata,
  output logic [IND_W-1:0]  u_ind,
  output logic [CNT_W-1:0]  u_wc,
  output logic [CNT_W-1:0]  u_adr
);
  always_comb begin
    wdata = '0;
    wdata[CNT_HI -: CNT_W] = loc;
    wdata[ADR_HI -: CNT_W] = adr;
    for (int i = 0; i < IND_W; i++) wdata[ind_pos(i)] = ind[i];
  end

  genvar g;
  generate
    for (g = 0; g < IND_W; g++) begin : g_ind
      assign u_ind[g] = rdata[ind_pos(g)];
    end
  endgenerate

  assign u_wc  = rdata[CNT_HI -: CNT_W];
  assign u_adr = rdata[ADR_HI -: CNT_W];
endmodule

// File: rtl/ccw_regs.sv
module ccw_regs
  import ccw_pkg::*;
#(
  parameter int STATUS_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic [CNT_W-1:0] cmd_addr,
  input  logic loc_en,
  input  logic clr_status,
  input  logic [STATUS_W-1:0] status_set,
  input  logic fill,
  input  logic [IND_W-1:0] u_ind,
  input  logic [CNT_W-1:0] u_wc,
  input  logic [CNT_W-1:0] u_adr,
  output logic [CNT_W-1:0] opnd_q,
  output logic [CNT_W-1:0] loc_q,
  output logic [CNT_W-1:0] adr_q,
  output logic [CNT_W-1:0] wc_q,
  output logic [IND_W-1:0] ind_q,
  output logic [STATUS_W-1:0] status_q
);
  logic [CNT_W-1:0] opnd_d, loc_d, adr_d, wc_d;
  logic [IND_W-1:0] ind_d;

  always_comb begin
    opnd_d = accept ? cmd_addr : opnd_q;
    loc_d  = loc_en ? opnd_q   : loc_q;
    adr_d  = fill   ? u_adr    : adr_q;
    wc_d   = fill   ? u_wc     : wc_q;
    ind_d  = fill   ? u_ind    : ind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      loc_q  <= '0;
      adr_q  <= '0;
      wc_q   <= '0;
      ind_q  <= '0;
    end else begin
      opnd_q <= opnd_d;
      loc_q  <= loc_d;
      adr_q  <= adr_d;
      wc_q   <= wc_d;
      ind_q  <= ind_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < STATUS_W; g++) begin : g_stat
      logic flag_d;
      always_comb flag_d = clr_status ? 1'b0 : (status_q[g] | status_set[g]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[g] <= 1'b0;
        else        status_q[g] <= flag_d;
      end
    end
  endgenerate
endmodule

// File: rtl/ccw_unit.sv
module ccw_unit
  import ccw_pkg::*;
#(
  parameter int STATUS_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          op,
  input  logic [CNT_W-1:0]    cmd_addr,
  input  logic [STATUS_W-1:0] status_set,
  output logic                mem_req,
  output logic                mem_we,
  output logic [CNT_W-1:0]    mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_rvalid,
  output logic                busy,
  output logic                done,
  output logic [CNT_W-1:0]    loc_q,
  output logic [CNT_W-1:0]    addr_q,
  output logic [CNT_W-1:0]    wc_q,
  output logic [IND_W-1:0]    ind_q,
  output logic [STATUS_W-1:0] status_q
);
  logic accept, lph, req, fill, is_store, is_rload;
  logic [IND_W-1:0] u_ind;
  logic [CNT_W-1:0] u_wc, u_adr, opnd;

  ccw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rvalid(mem_rvalid),
    .accept(accept), .lph(lph), .req(req), .fill(fill), .done(done),
    .busy(busy), .is_store(is_store), .is_rload(is_rload)
  );

  ccw_regs #(.STATUS_W(STATUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cmd_addr(cmd_addr),
    .loc_en(lph && !is_store), .clr_status(lph && is_rload),
    .status_set(status_set), .fill(fill),
    .u_ind(u_ind), .u_wc(u_wc), .u_adr(u_adr),
    .opnd_q(opnd), .loc_q(loc_q), .adr_q(addr_q), .wc_q(wc_q),
    .ind_q(ind_q), .status_q(status_q)
  );

  ccw_pack u_pack (
    .ind(ind_q), .loc(loc_q), .adr(addr_q), .wdata(mem_wdata),
    .rdata(mem_rdata), .u_ind(u_ind), .u_wc(u_wc), .u_adr(u_adr)
  );

  assign mem_req  = req;
  assign mem_we   = req && is_store;
  assign mem_addr = opnd;
endmodule

// File: rtl/ccw_unit_chk.sv
module ccw_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mem_req,
  input logic        mem_we,
  input logic [35:0] mem_wdata,
  input logic        busy,
  input logic        done,
  input logic [14:0] loc_q,
  input logic [14:0] addr_q,
  input logic [14:0] wc_q,
  input logic [3:0]  ind_q
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r3_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  a_r6_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[17] == 1'b0 && mem_wdata[15] == 1'b0));
  a_r7_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> ($stable(addr_q) && $stable(wc_q) && $stable(ind_q) && $stable(loc_q)));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(addr_q) && $stable(wc_q) && $stable(ind_q) && $stable(loc_q)));
endmodule

bind ccw_unit ccw_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .busy(busy), .done(done), .loc_q(loc_q),
  .addr_q(addr_q), .wc_q(wc_q), .ind_q(ind_q)
);

// File: tb/tb_ccw_unit.sv
module tb_ccw_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'b11;
  logic [14:0] cmd_addr = '0;
  logic [1:0] status_set = '0;
  logic mem_req, mem_we, busy, done;
  logic [14:0] mem_addr, loc_q, addr_q, wc_q;
  logic [35:0] mem_wdata;
  logic [35:0] mem_rdata = '0;
  logic mem_rvalid = 1'b0;
  logic [3:0] ind_q;
  logic [1:0] status_q;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ccw_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cmd_addr(cmd_addr),
    .status_set(status_set), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .busy(busy), .done(done), .loc_q(loc_q),
    .addr_q(addr_q), .wc_q(wc_q), .ind_q(ind_q), .status_q(status_q)
  );

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit n of the S,1..35 numbering lives at index 35-n
  function automatic logic [35:0] mk_word(input logic [3:0] ind, input logic [14:0] mid, input logic [14:0] low);
    logic [35:0] w = '0;
    w[35] = ind[3]; w[34] = ind[2]; w[33] = ind[1]; w[16] = ind[0];
    for (int b = 0; b < 15; b++) begin
      w[18 + b] = mid[b];
      w[b]      = low[b];
    end
    return w;
  endfunction

  task automatic nclk(); @(negedge clk); endtask

  // full fetch; returns after done has been checked
  task automatic do_fetch(input logic [1:0] o, input logic [14:0] a, input logic [35:0] word,
                          input logic [3:0] e_ind, input logic [14:0] e_wc, input logic [14:0] e_adr);
    start = 1'b1; op = o; cmd_addr = a;
    nclk(); start = 1'b0;
    chk(busy && !mem_req, "R3 no request in L phase", {34'b0, busy, mem_req}, 36'h2);
    nclk();
    chk(loc_q == a, "R2 location counter", 36'(loc_q), 36'(a));
    chk(mem_req && !mem_we && mem_addr == a, "R3 read request", {20'b0, mem_req, mem_we, mem_addr}, {20'b0, 2'b10, a});
    nclk();
    chk(!mem_req, "R3 request one cycle", 36'(mem_req), 36'h0);
    mem_rdata = word; mem_rvalid = 1'b1;
    nclk(); mem_rvalid = 1'b0; mem_rdata = '0;
    chk(done, "R8 done after fetch", 36'(done), 36'h1);
    chk(ind_q == e_ind && wc_q == e_wc && addr_q == e_adr, "R4 field unpack",
        {2'b0, ind_q, wc_q, addr_q}, {2'b0, e_ind, e_wc, e_adr});
    nclk();
    chk(!done && !busy, "R8 done one cycle", {34'b0, done, busy}, 36'h0);
  endtask

  task automatic do_store(input logic [14:0] a, input logic [35:0] e_word);
    logic [14:0] l0, a0, w0;
    logic [3:0] i0;
    l0 = loc_q; a0 = addr_q; w0 = wc_q; i0 = ind_q;
    start = 1'b1; op = 2'b10; cmd_addr = a;
    nclk(); start = 1'b0;
    nclk();
    chk(mem_req && mem_we && mem_addr == a, "R3 write request", {20'b0, mem_req, mem_we, mem_addr}, {20'b0, 2'b11, a});
    chk(mem_wdata == e_word, "R6 store packing", mem_wdata, e_word);
    nclk();
    chk(done, "R8 done after store", 36'(done), 36'h1);
    chk(loc_q == l0 && addr_q == a0 && wc_q == w0 && ind_q == i0, "R7 store keeps registers",
        {ind_q, loc_q[1:0], addr_q, wc_q}, {i0, l0[1:0], a0, w0});
    nclk();
  endtask

  initial begin
    repeat (3) nclk();
    chk(!busy && !done && !mem_req, "R1 reset control", {33'b0, busy, done, mem_req}, 36'h0);
    chk(loc_q == 0 && addr_q == 0 && wc_q == 0 && ind_q == 0 && status_q == 0, "R1 reset registers",
        {2'b0, ind_q, status_q, loc_q[0], addr_q, wc_q[12:0]}, 36'h0);
    rst_n = 1'b1;
    nclk();

    // R4/R6 sweep: all indicator codes x walking one in the counter fields
    for (int iv = 0; iv < 16; iv++) begin
      for (int k = 0; k < 15; k++) begin
        logic [14:0] wcv, adv, ca;
        logic [35:0] w;
        wcv = 15'(1 << k);
        adv = ~wcv;
        ca  = 15'((k * 1111 + iv * 37) & 15'h7fff);
        w = mk_word(4'(iv), wcv, adv);
        w[17] = 1'b1; w[15] = 1'b1;  // bits 18 and 20: no effect (R4)
        do_fetch(2'b00, ca, w, 4'(iv), wcv, adv);
        do_store(15'(ca ^ 15'h5555), mk_word(4'(iv), ca, adv));
      end
    end

    // R11 / R5 status flags
    status_set = 2'b10; nclk(); status_set = 2'b00;
    chk(status_q == 2'b10, "R11 set flag", 36'(status_q), 36'h2);
    status_set = 2'b01; nclk(); status_set = 2'b00; nclk();
    chk(status_q == 2'b11, "R11 flags hold", 36'(status_q), 36'h3);
    do_fetch(2'b00, 15'h0123, mk_word(4'h5, 15'h0f0f, 15'h7001), 4'h5, 15'h0f0f, 15'h7001);
    chk(status_q == 2'b11, "R5 plain fetch keeps flags", 36'(status_q), 36'h3);
    do_fetch(2'b01, 15'h4321, mk_word(4'hA, 15'h1234, 15'h0777), 4'hA, 15'h1234, 15'h0777);
    chk(status_q == 2'b00, "R5 reset-and-load clears flags", 36'(status_q), 36'h0);

    // R9 op 11 ignored
    start = 1'b1; op = 2'b11; cmd_addr = 15'h7777;
    nclk(); start = 1'b0;
    chk(!busy, "R9 op 11 ignored", 36'(busy), 36'h0);
    nclk();
    chk(!mem_req && loc_q == 15'h4321, "R9 op 11 no effect", {20'b0, mem_req, loc_q}, {21'b0, 15'h4321});

    // R9 start while busy ignored
    start = 1'b1; op = 2'b00; cmd_addr = 15'h0aaa;
    nclk(); op = 2'b10; cmd_addr = 15'h1555;
    nclk(); start = 1'b0;
    chk(mem_req && !mem_we && mem_addr == 15'h0aaa, "R9 busy start ignored",
        {20'b0, mem_req, mem_we, mem_addr}, {20'b0, 2'b10, 15'h0aaa});
    nclk();
    mem_rdata = mk_word(4'h3, 15'h0055, 15'h2222); mem_rvalid = 1'b1;
    nclk(); mem_rvalid = 1'b0;
    chk(done && wc_q == 15'h0055 && addr_q == 15'h2222, "R9 original fetch completes",
        {20'b0, done, wc_q}, {20'b0, 1'b1, 15'h0055});
    nclk();

    // R10 stray read-valid while idle
    mem_rdata = 36'hfffffffff; mem_rvalid = 1'b1;
    nclk(); mem_rvalid = 1'b0; nclk();
    chk(ind_q == 4'h3 && wc_q == 15'h0055 && addr_q == 15'h2222 && !done, "R10 stray valid ignored",
        {1'b0, done, ind_q, wc_q, addr_q}, {2'b0, 4'h3, 15'h0055, 15'h2222});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule